// File: doc/BRIEF.md
# Segmented DAC Thermometer Decoder

This block is the digital front end of a 14-bit segmented current-steering converter. A parallel unsigned code is captured on the rising clock edge and split into three fields. The top field sets how many of a row of identical coarse elements are switched to the A side. The middle field does the same for a row of identical fine elements. The bottom field drives a small set of binary-weighted elements directly. Every element gets a true and a complement drive from its own flop, so each element is steered either to output A or to output B, and both drives change on the same edge.

The word passes through two register stages. The first holds the input code. The second holds the decoded steering pattern. A sleep input parks every element on the B side and freezes the held input code. The weights are: a coarse element is worth 512 codes, a fine element 32 codes, and the binary bits 16, 8, 4, 2 and 1. With those weights, the total weight on side A always equals the code.

Top module: `segdac_front`

## Requirements
- R1: A code present at a rising edge, with sleep low at that edge and at the next one, appears on the steering outputs after that next edge, which is two edges after it was driven.
- R2: With N = code[13:9], coarse elements 0 to N-1 are on the A side (msb_a bit i = 1 for i < N) and all the others are on the B side.
- R3: With M = code[8:5], fine elements 0 to M-1 are on the A side (mid_a bit i = 1 for i < M) and all the others are on the B side.
- R4: lsb_a equals code[4:0] bit for bit, with binary weights 16, 8, 4, 2 and 1.
- R5: 512·popcount(msb_a) + 32·popcount(mid_a) + lsb_a equals the code, for every code from 0 to 16383.
- R6: Each B output is the exact bitwise complement of its A output in every cycle.
- R7: Code 16383 puts every element on side A. Code 0 puts every element on side B.
- R8: At an edge where sleep is high, every element goes to side B and the held input code keeps its value, so input codes presented during sleep are ignored. At the first edge with sleep low, the outputs show the code that was held before sleep.
- R9: A synchronous reset clears the held code to 0 and puts every element on side B at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Park all elements on side B and freeze the held code, active high |
| code_in | input | 14 | Unsigned input code |
| msb_a | output | 31 | Coarse elements, A-side drive |
| msb_b | output | 31 | Coarse elements, B-side drive |
| mid_a | output | 15 | Fine elements, A-side drive |
| mid_b | output | 15 | Fine elements, B-side drive |
| lsb_a | output | 5 | Binary elements, A-side drive |
| lsb_b | output | 5 | Binary elements, B-side drive |

## Verification
Sleep and a fresh input code can arrive in the same cycle. Sleep is raised at the same edge where a new code is driven, and further codes are changed while sleep stays high. The bench judges two things: the outputs must sit fully on side B, and after wake-up the first output must be the code held before sleep, with the code driven at release following one edge later. Reset arriving while a full-scale code is streaming is also judged, by requiring an all-B output after the reset edge.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

   // Decoder implementation variant for a thermometer segment
   typedef enum logic [0:0] {
      DEC_COMPARE = 1'b0,
      DEC_SHIFT   = 1'b1
   } dec_style_e;

   // Number of unary elements produced by a segment of the given width
   function automatic int unsigned unit_count(input int unsigned bits);
      return (1 << bits) - 1;
   endfunction

endpackage

// File: rtl/segdac_in_latch.sv
module segdac_in_latch #(
   parameter int unsigned W = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sleep,
   input  logic [W-1:0] din,
   output logic [W-1:0] word_q
);

   always_ff @(posedge clk) begin
      if (rst)
         word_q <= '0;
      else if (!sleep)
         word_q <= din;
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) sleep |=> $stable(word_q)); // R8

endmodule

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec
   import segdac_pkg::*;
#(
   parameter int unsigned BITS  = 5,
   parameter dec_style_e  STYLE = DEC_COMPARE,
   localparam int unsigned UNITS = (1 << BITS) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [BITS-1:0]  level,
   output logic [UNITS-1:0] therm
);

   if (BITS < 1 || BITS > 6) begin : g_bad_bits
      $error("segdac_therm_dec: BITS must lie in 1..6");
   end

   if (STYLE == DEC_COMPARE) begin : g_cmp
      for (genvar i = 0; i < UNITS; i++) begin : g_unit
         assign therm[i] = (level > BITS'(i));
      end
   end else begin : g_shift
      assign therm = ~({UNITS{1'b1}} << level);
   end

   AST_THERM_COUNT: assert property (@(posedge clk) disable iff (rst) $countones(therm) == int'(level)); // R2
   AST_THERM_BASE:  assert property (@(posedge clk) disable iff (rst) (level != '0) |-> therm[0]); // R3

endmodule

// File: rtl/segdac_steer_reg.sv
module segdac_steer_reg #(
   parameter int unsigned N = 31
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sleep,
   input  logic [N-1:0] sel,
   output logic [N-1:0] a_q,
   output logic [N-1:0] b_q
);

   // Separate flops for both rails so they switch on one edge
   always_ff @(posedge clk) begin
      if (rst || sleep) begin
         a_q <= '0;
         b_q <= '1;
      end else begin
         a_q <= sel;
         b_q <= ~sel;
      end
   end

   AST_RAILS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst) (a_q ^ b_q) == '1); // R6
   AST_SLEEP_PARK:       assert property (@(posedge clk) disable iff (rst) sleep |=> (a_q == '0 && b_q == '1)); // R8
   AST_RESET_PARK:       assert property (@(posedge clk) rst |=> (a_q == '0)); // R9

endmodule

// File: rtl/segdac_front.sv
module segdac_front
   import segdac_pkg::*;
#(
   parameter int unsigned MSB_BITS  = 5,
   parameter int unsigned MID_BITS  = 4,
   parameter int unsigned LSB_BITS  = 5,
   parameter dec_style_e  MSB_STYLE = DEC_COMPARE,
   parameter dec_style_e  MID_STYLE = DEC_SHIFT,
   localparam int unsigned W        = MSB_BITS + MID_BITS + LSB_BITS,
   localparam int unsigned MSB_N    = (1 << MSB_BITS) - 1,
   localparam int unsigned MID_N    = (1 << MID_BITS) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sleep,
   input  logic [W-1:0]     code_in,
   output logic [MSB_N-1:0] msb_a,
   output logic [MSB_N-1:0] msb_b,
   output logic [MID_N-1:0] mid_a,
   output logic [MID_N-1:0] mid_b,
   output logic [LSB_BITS-1:0] lsb_a,
   output logic [LSB_BITS-1:0] lsb_b
);

   localparam int unsigned MID_LO = LSB_BITS;
   localparam int unsigned MSB_LO = LSB_BITS + MID_BITS;

   if (LSB_BITS < 1 || LSB_BITS > 8) begin : g_bad_lsb
      $error("segdac_front: LSB_BITS must lie in 1..8");
   end
   if (unit_count(MSB_BITS) != MSB_N || unit_count(MID_BITS) != MID_N) begin : g_bad_units
      $error("segdac_front: element count mismatch");
   end

   logic [W-1:0]        word_q;
   logic [MSB_N-1:0]    msb_sel;
   logic [MID_N-1:0]    mid_sel;

   segdac_in_latch #(.W(W)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .sleep  (sleep),
      .din    (code_in),
      .word_q (word_q)
   );

   segdac_therm_dec #(.BITS(MSB_BITS), .STYLE(MSB_STYLE)) u_msb_dec (
      .clk   (clk),
      .rst   (rst),
      .level (word_q[MSB_LO +: MSB_BITS]),
      .therm (msb_sel)
   );

   segdac_therm_dec #(.BITS(MID_BITS), .STYLE(MID_STYLE)) u_mid_dec (
      .clk   (clk),
      .rst   (rst),
      .level (word_q[MID_LO +: MID_BITS]),
      .therm (mid_sel)
   );

   segdac_steer_reg #(.N(MSB_N)) u_msb_reg (
      .clk   (clk),
      .rst   (rst),
      .sleep (sleep),
      .sel   (msb_sel),
      .a_q   (msb_a),
      .b_q   (msb_b)
   );

   segdac_steer_reg #(.N(MID_N)) u_mid_reg (
      .clk   (clk),
      .rst   (rst),
      .sleep (sleep),
      .sel   (mid_sel),
      .a_q   (mid_a),
      .b_q   (mid_b)
   );

   segdac_steer_reg #(.N(LSB_BITS)) u_lsb_reg (
      .clk   (clk),
      .rst   (rst),
      .sleep (sleep),
      .sel   (word_q[LSB_BITS-1:0]),
      .a_q   (lsb_a),
      .b_q   (lsb_b)
   );

   AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
      (!sleep && (&word_q)) |=> ((&msb_a) && (&mid_a) && (&lsb_a))); // R7
   AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (rst)
      (!sleep && word_q == '0) |=> ((&msb_b) && (&mid_b) && (&lsb_b))); // R7
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (word_q == '0)); // R9

endmodule

// File: tb/sim_segdac_front.sv
module sim_segdac_front;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sleep = 1'b0;
   logic [13:0] code_in = '0;
   logic [30:0] msb_a, msb_b;
   logic [14:0] mid_a, mid_b;
   logic [4:0]  lsb_a, lsb_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5ns clk = ~clk;

   segdac_front u0 (
      .clk     (clk),
      .rst     (rst),
      .sleep   (sleep),
      .code_in (code_in),
      .msb_a   (msb_a),
      .msb_b   (msb_b),
      .mid_a   (mid_a),
      .mid_b   (mid_b),
      .lsb_a   (lsb_a),
      .lsb_b   (lsb_b)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Full decode check for a code (R2..R6)
   task automatic check_code(input int code);
      longint m_exp   = (64'd1 << (code >> 9)) - 1;
      longint d_exp   = (64'd1 << ((code >> 5) & 15)) - 1;
      int     sum_a   = 512 * $countones(msb_a) + 32 * $countones(mid_a) + int'(lsb_a);
      check(msb_a == 31'(m_exp), "R2 coarse", longint'(msb_a), m_exp);
      check(mid_a == 15'(d_exp), "R3 fine", longint'(mid_a), d_exp);
      check(lsb_a == 5'(code & 31), "R4 binary", longint'(lsb_a), longint'(code & 31));
      check(sum_a == code, "R5 weight sum", longint'(sum_a), longint'(code));
      check(msb_b == ~msb_a && mid_b == ~mid_a && lsb_b == ~lsb_a, "R6 complement",
            longint'({msb_b, mid_b, lsb_b}), longint'({~msb_a, ~mid_a, ~lsb_a}));
   endtask

   task automatic check_all_b(input string req);
      check(msb_a == '0 && mid_a == '0 && lsb_a == '0 && msb_b == '1 && mid_b == '1 && lsb_b == '1,
            req, longint'({msb_a, mid_a, lsb_a}), 0);
   endtask

   initial begin
      #1500us;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int prev;
      // R9: reset with a nonzero code on the input
      code_in = 14'd12345;
      repeat (3) @(negedge clk);
      check_all_b("R9 reset state");
      rst = 1'b0;

      // R1, R2..R6: exhaustive streaming sweep
      prev = -1;
      for (int c = 0; c <= 16384; c++) begin
         if (c <= 16383) code_in = 14'(c);
         @(negedge clk);
         if (prev >= 0) check_code(prev);
         if (prev == 16383) check(&msb_a && &mid_a && &lsb_a, "R7 full scale A", longint'({msb_a, mid_a, lsb_a}), 51'h7_FFFF_FFFF_FFFF);
         if (prev == 0) check_all_b("R7 zero code B");
         prev = c;
      end

      // R1: single-step latency
      code_in = 14'd4660;
      @(negedge clk);
      code_in = 14'd100;
      @(negedge clk);
      check_code(4660);
      check(512 * $countones(msb_a) + 32 * $countones(mid_a) + int'(lsb_a) == 4660, "R1 latency", 0, 4660);
      @(negedge clk);
      check_code(100);

      // R8: sleep raised together with a new code
      code_in = 14'd9000;
      repeat (2) @(negedge clk);
      check_code(9000);
      sleep = 1'b1;
      code_in = 14'd100;
      @(negedge clk);
      check_all_b("R8 sleep parks B");
      code_in = 14'd15000;
      @(negedge clk);
      check_all_b("R8 sleep parks B");
      code_in = 14'd77;
      @(negedge clk);
      check_all_b("R8 sleep parks B");
      sleep = 1'b0;
      code_in = 14'd5000;
      @(negedge clk);
      check_code(9000);
      check(512 * $countones(msb_a) + 32 * $countones(mid_a) + int'(lsb_a) == 9000, "R8 held code", 0, 9000);
      @(negedge clk);
      check_code(5000);

      // R9: reset while a full-scale code streams
      code_in = 14'd16383;
      repeat (2) @(negedge clk);
      check_code(16383);
      rst = 1'b1;
      @(negedge clk);
      check_all_b("R9 reset mid-stream");
      rst = 1'b0;
      code_in = 14'd1;
      repeat (2) @(negedge clk);
      check_code(1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule